// File: doc/BRIEF.md
# Sand-Castle Timing Pulse Generator

This block builds, once per video line, a combined timing code for the analog level driver that follows it. The code has three levels. The top level marks the colour burst gate. The middle level marks horizontal blanking, and it also covers the whole line during vertical blanking. The bottom level marks everything else. Two 2-bit selectors each move one edge of the burst gate in steps of four clocks, which is 0.4 µs at a 10 MHz clock. The block samples both selectors at each line start, so a line always uses one consistent pair of settings.

The block also counts the active lines of each field and raises a line mask flag when masking is enabled. Downstream logic uses the flag to replace the picture with a flat DC level. The flag covers the first three active lines of a field. It also covers the last three lines, where the end of the field is predicted from the length of the previous field.

Top module: `scp_gen`

## Requirements
- R1: While `rst` is high, `scp_level` is 2'b00 and `line_mask` is 0. Reset starts a line at offset 0 with both edge selectors at the nominal code 1, whatever the selector inputs are. `line_mask` stays 0 until an `href` arrives while `vblank` is low.
- R2: `scp_level` encodes low as 2'b00, blanking as 2'b01 and burst gate as 2'b10. Burst gate outranks blanking, and blanking outranks low. The value 2'b11 never appears.
- R3: Offset n counts clock edges, starting at 0 on the edge that samples `href` high. The code for offset n is presented from the following edge on. Offsets 0 to 119 show at least the blanking level.
- R4: With both selectors at code 1, the burst gate level covers offsets 54 to 93 inclusive.
- R5: The rising-edge selector code c puts the first burst offset at 54+d(c). The falling-edge selector code c puts the first offset after the burst at 94+d(c). Here d(0)=+4, d(1)=0, d(2)=-4 and d(3)=-8. The two selectors act independently.
- R6: The selector values sampled with `href` apply to the whole line. Changes to them during the line have no effect until the next `href`.
- R7: During a line whose `vblank` is high, every offset outside the burst window shows blanking (2'b01), and the burst window still shows 2'b10.
- R8: When `vblank` is low, offsets from 120 onward show 2'b00. This holds however long the line lasts, because the offset count stops at its maximum and does not wrap.
- R9: Active lines are indexed from 0 at each `href` seen while `vblank` is low, and the index restarts after `vblank`. With `mask_en` high, lines 0, 1 and 2 set `line_mask`.
- R10: L is the number of active lines in the most recent completed field that had any. With `mask_en` high, lines with index i where i+3 >= L set `line_mask`. No tail masking happens before such a field exists.
- R11: `line_mask` is 0 while `mask_en` is low and on lines where `vblank` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock (10 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| href | input | 1 | One-clock horizontal reference pulse starting a line |
| vblank | input | 1 | High during vertical blanking lines |
| bg_rise_sel | input | 2 | Burst gate rising-edge step code |
| bg_fall_sel | input | 2 | Burst gate falling-edge step code |
| mask_en | input | 1 | Enables the head/tail line mask |
| scp_level | output | 2 | Three-level code: 00 low, 01 blanking, 10 burst |
| line_mask | output | 1 | High on lines to be replaced by DC |

## Verification
The bound checker watches, on every clock, that the reserved code 2'b11 never shows. It also watches that the level two clocks after a line start is blanking, that a vertical blanking line never drops to the low level, and that the mask only rises after an enabled, non-blanking clock. It also checks that reset holds both outputs quiet. The exact burst window for each of the sixteen selector pairs, the point at which selectors are sampled, and the stop at the end of a long line depend on counting whole lines. Only the bench scenarios show these. The same holds for the head and tail mask, which depends on the length of the previous field.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef enum logic [1:0] {
    SCP_LOW   = 2'b00,
    SCP_BLANK = 2'b01,
    SCP_BURST = 2'b10
  } scp_level_e;

  localparam logic [1:0] SCP_SEL_NOMINAL = 2'b01;
  localparam int         SCP_SEL_CODES   = 4;

  // Signed number of steps an edge moves for a selector code; positive is later.
  function automatic int scp_step_count(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 0;
      2'd2:    return -1;
      default: return -2;
    endcase
  endfunction

endpackage

// File: rtl/scp_line_timer.sv
module scp_line_timer
  import scp_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             href,
  input  logic [1:0]       rise_sel_in,
  input  logic [1:0]       fall_sel_in,
  output logic [POS_W-1:0] pos,
  output logic [1:0]       rise_sel,
  output logic [1:0]       fall_sel
);

  localparam logic [POS_W-1:0] POS_LAST = '1;

  // Offset within the line; stops at its maximum so a missing reference
  // never re-opens the blanking or burst windows.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (href) begin
      pos <= '0;
    end else if (pos != POS_LAST) begin
      pos <= pos + 1'b1;
    end
  end

  // Selector shadow: one set of edge codes per line.
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_sel <= SCP_SEL_NOMINAL;
      fall_sel <= SCP_SEL_NOMINAL;
    end else if (href) begin
      rise_sel <= rise_sel_in;
      fall_sel <= fall_sel_in;
    end
  end

endmodule

// File: rtl/scp_pulse_shaper.sv
module scp_pulse_shaper
  import scp_pkg::*;
#(
  parameter int POS_W     = 10,
  parameter int STEP_CLKS = 4,
  parameter int BG_START  = 54,
  parameter int BG_END    = 94,
  parameter int HBLK_END  = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  input  logic [1:0]       rise_sel,
  input  logic [1:0]       fall_sel,
  input  logic             vblank,
  output logic [1:0]       level_code
);

  localparam logic [POS_W-1:0] HBLK_LIMIT = POS_W'(HBLK_END);

  logic [POS_W-1:0] rise_tab [SCP_SEL_CODES];
  logic [POS_W-1:0] fall_tab [SCP_SEL_CODES];

  // One pre-computed edge position per selector code.
  for (genvar g = 0; g < SCP_SEL_CODES; g++) begin : g_edge
    localparam int RISE_AT = BG_START + STEP_CLKS * scp_step_count(2'(g));
    localparam int FALL_AT = BG_END   + STEP_CLKS * scp_step_count(2'(g));
    assign rise_tab[g] = POS_W'(RISE_AT);
    assign fall_tab[g] = POS_W'(FALL_AT);
  end

  logic [POS_W-1:0] rise_at;
  logic [POS_W-1:0] fall_at;
  logic             in_burst;
  logic             in_hblank;
  scp_level_e       level_d;
  scp_level_e       level_q;

  always_comb begin
    rise_at   = rise_tab[rise_sel];
    fall_at   = fall_tab[fall_sel];
    in_burst  = (pos >= rise_at) && (pos < fall_at);
    in_hblank = (pos < HBLK_LIMIT);
    if (in_burst) begin
      level_d = SCP_BURST;
    end else if (in_hblank || vblank) begin
      level_d = SCP_BLANK;
    end else begin
      level_d = SCP_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= SCP_LOW;
    end else begin
      level_q <= level_d;
    end
  end

  assign level_code = level_q;

endmodule

// File: rtl/scp_field_mask.sv
module scp_field_mask #(
  parameter int LINE_W     = 10,
  parameter int EDGE_LINES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic href,
  input  logic vblank,
  input  logic mask_en,
  output logic line_mask
);

  localparam logic [LINE_W-1:0] LINE_LAST = '1;
  localparam logic [LINE_W-1:0] EDGE_N    = LINE_W'(EDGE_LINES);
  localparam logic [LINE_W:0]   EDGE_NW   = (LINE_W+1)'(EDGE_LINES);

  logic              vblank_d;
  logic              in_video;
  logic              len_valid;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] cur_line;
  logic [LINE_W-1:0] field_len;
  logic              head_hit;
  logic              tail_hit;
  logic              mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vblank_d  <= 1'b0;
      in_video  <= 1'b0;
      len_valid <= 1'b0;
      line_cnt  <= '0;
      cur_line  <= '0;
      field_len <= '0;
    end else begin
      vblank_d <= vblank;
      // Field length is latched as vertical blanking begins after video.
      if (vblank && !vblank_d && in_video) begin
        field_len <= line_cnt;
        len_valid <= 1'b1;
      end
      if (vblank) begin
        line_cnt <= '0;
        in_video <= 1'b0;
      end else if (href) begin
        cur_line <= line_cnt;
        in_video <= 1'b1;
        if (line_cnt != LINE_LAST) begin
          line_cnt <= line_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    head_hit = (cur_line < EDGE_N);
    tail_hit = len_valid && (({1'b0, cur_line} + EDGE_NW) >= {1'b0, field_len});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
    end else begin
      mask_q <= mask_en && !vblank && in_video && (head_hit || tail_hit);
    end
  end

  assign line_mask = mask_q;

endmodule

// File: rtl/scp_gen.sv
module scp_gen #(
  parameter int POS_W      = 10,
  parameter int LINE_W     = 10,
  parameter int STEP_CLKS  = 4,
  parameter int BG_START   = 54,
  parameter int BG_END     = 94,
  parameter int HBLK_END   = 120,
  parameter int EDGE_LINES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       href,
  input  logic       vblank,
  input  logic [1:0] bg_rise_sel,
  input  logic [1:0] bg_fall_sel,
  input  logic       mask_en,
  output logic [1:0] scp_level,
  output logic       line_mask
);

  logic [POS_W-1:0] pos;
  logic [1:0]       rise_sel;
  logic [1:0]       fall_sel;

  scp_line_timer #(
    .POS_W(POS_W)
  ) i_timer (
    .clk        (clk),
    .rst        (rst),
    .href       (href),
    .rise_sel_in(bg_rise_sel),
    .fall_sel_in(bg_fall_sel),
    .pos        (pos),
    .rise_sel   (rise_sel),
    .fall_sel   (fall_sel)
  );

  scp_pulse_shaper #(
    .POS_W    (POS_W),
    .STEP_CLKS(STEP_CLKS),
    .BG_START (BG_START),
    .BG_END   (BG_END),
    .HBLK_END (HBLK_END)
  ) i_shaper (
    .clk       (clk),
    .rst       (rst),
    .pos       (pos),
    .rise_sel  (rise_sel),
    .fall_sel  (fall_sel),
    .vblank    (vblank),
    .level_code(scp_level)
  );

  scp_field_mask #(
    .LINE_W    (LINE_W),
    .EDGE_LINES(EDGE_LINES)
  ) i_mask (
    .clk      (clk),
    .rst      (rst),
    .href     (href),
    .vblank   (vblank),
    .mask_en  (mask_en),
    .line_mask(line_mask)
  );

endmodule

// File: rtl/scp_gen_chk.sv
module scp_gen_chk
  import scp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       href,
  input logic       vblank,
  input logic       mask_en,
  input logic [1:0] level,
  input logic       mask
);

  logic [1:0] age;
  logic       rst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= 2'd0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      AST_RESET_QUIET: assert (level == SCP_LOW && !mask); // R1
    end
  end

  AST_LEVEL_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    level != 2'b11); // R2

  AST_BLANK_AFTER_HREF: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(href, 2)) |-> (level == SCP_BLANK)); // R3

  AST_VBLANK_NEVER_LOW: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $past(vblank)) |-> (level != SCP_LOW)); // R7

  AST_MASK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && mask) |-> $past(mask_en)); // R11

  AST_MASK_OFF_IN_VBLANK: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && mask) |-> !$past(vblank)); // R11

endmodule

bind scp_gen scp_gen_chk i_chk (
  .clk    (clk),
  .rst    (rst),
  .href   (href),
  .vblank (vblank),
  .mask_en(mask_en),
  .level  (scp_level),
  .mask   (line_mask)
);

// File: tb/test_scp_gen.sv
module test_scp_gen;

  logic       clk = 1'b0;
  logic       rst;
  logic       href;
  logic       vblank;
  logic [1:0] bg_rise_sel;
  logic [1:0] bg_fall_sel;
  logic       mask_en;
  logic [1:0] scp_level;
  logic       line_mask;

  int total = 0;
  int bad   = 0;

  // bench field model
  int act_idx = 0;
  int lprev   = 0;
  bit lvalid  = 1'b0;

  always #5 clk = ~clk;

  scp_gen i_scp_gen (
    .clk        (clk),
    .rst        (rst),
    .href       (href),
    .vblank     (vblank),
    .bg_rise_sel(bg_rise_sel),
    .bg_fall_sel(bg_fall_sel),
    .mask_en    (mask_en),
    .scp_level  (scp_level),
    .line_mask  (line_mask)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int delta(input bit [1:0] c);
    case (c)
      2'd0: return 4;
      2'd1: return 0;
      2'd2: return -4;
      default: return -8;
    endcase
  endfunction

  function automatic int exp_lvl(input int n, input bit [1:0] rc, input bit [1:0] fc, input bit vb);
    if (n >= 54 + delta(rc) && n < 94 + delta(fc)) return 2;
    if (n < 120 || vb) return 1;
    return 0;
  endfunction

  function automatic string lvl_tag(input int n, input bit [1:0] rc, input bit [1:0] fc, input bit vb);
    if (vb) return "R7";
    if (n >= 54 + delta(rc) && n < 94 + delta(fc)) return (rc == 2'd1 && fc == 2'd1) ? "R4" : "R5";
    if (n < 120) return "R3";
    return "R8";
  endfunction

  // Assumes the caller stands at a falling clock edge.
  task automatic run_line(input int len, input bit vb, input bit [1:0] rc, input bit [1:0] fc,
                          input bit men, input string otag = "", input int chg_at = -1,
                          input bit [1:0] rc2 = 2'd0, input bit [1:0] fc2 = 2'd0);
    bit    exp_m;
    string mtag;
    if (vb) begin
      if (act_idx > 0) begin
        lprev  = act_idx;
        lvalid = 1'b1;
      end
      act_idx = 0;
      exp_m   = 1'b0;
      mtag    = "R11";
    end else begin
      exp_m = men && (act_idx < 3 || (lvalid && act_idx + 3 >= lprev));
      mtag  = !men ? "R11" : (act_idx < 3 ? "R9" : "R10");
      act_idx++;
    end
    href = 1'b1; vblank = vb; bg_rise_sel = rc; bg_fall_sel = fc; mask_en = men;
    @(negedge clk);
    href = 1'b0;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      chk(scp_level == exp_lvl(n, rc, fc, vb), (otag != "") ? otag : lvl_tag(n, rc, fc, vb),
          scp_level, exp_lvl(n, rc, fc, vb));
      chk(scp_level != 2'b11, "R2", scp_level, 0);
      chk(line_mask == exp_m, mtag, line_mask, exp_m);
      if (n == chg_at) begin
        bg_rise_sel = rc2;
        bg_fall_sel = fc2;
      end
    end
  endtask

  task automatic run_field(input int nvb, input int nact, input bit men, input bit rnd);
    for (int i = 0; i < nvb; i++)
      run_line(rnd ? $urandom_range(121, 170) : 140, 1'b1,
               rnd ? 2'($urandom_range(0, 3)) : 2'd1, rnd ? 2'($urandom_range(0, 3)) : 2'd1, men);
    for (int i = 0; i < nact; i++)
      run_line(rnd ? $urandom_range(121, 170) : 130, 1'b0,
               rnd ? 2'($urandom_range(0, 3)) : 2'd1, rnd ? 2'($urandom_range(0, 3)) : 2'd1, men);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    rst = 1'b1; href = 1'b0; vblank = 1'b0;
    bg_rise_sel = 2'd3; bg_fall_sel = 2'd0; mask_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(scp_level == 2'b00, "R1", scp_level, 0);
    chk(line_mask == 1'b0, "R1", line_mask, 0);
    rst = 1'b0;
    // R1: reset starts a nominal line regardless of selector inputs
    for (int n = 0; n < 140; n++) begin
      @(negedge clk);
      chk(scp_level == exp_lvl(n, 2'd1, 2'd1, 1'b0), "R1", scp_level, exp_lvl(n, 2'd1, 2'd1, 1'b0));
      chk(line_mask == 1'b0, "R1", line_mask, 0);
    end
    // R4 / R5: every selector pair
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 4; f++)
        run_line(140, 1'b0, 2'(r), 2'(f), 1'b0);
    // R6: mid-line selector change is ignored for the current line
    run_line(140, 1'b0, 2'd1, 2'd1, 1'b0, "R6", 20, 2'd3, 2'd0);
    run_line(140, 1'b0, 2'd2, 2'd3, 1'b0, "R6", 60, 2'd0, 2'd0);
    run_line(140, 1'b0, 2'd0, 2'd0, 1'b0, "R6");
    // R7: vertical blanking lines
    run_line(140, 1'b1, 2'd1, 2'd1, 1'b1);
    run_line(140, 1'b1, 2'd3, 2'd0, 1'b1);
    // R8: long line without a reference does not wrap
    run_line(1100, 1'b0, 2'd1, 2'd1, 1'b0);
    // R9 / R10: head and tail masking over directed fields
    run_field(2, 8, 1'b1, 1'b0);
    run_field(1, 8, 1'b1, 1'b0);
    run_field(2, 4, 1'b1, 1'b0);
    run_field(1, 6, 1'b1, 1'b0);
    // R11: disabled mask
    run_field(1, 7, 1'b0, 1'b0);
    // random fields
    for (int k = 0; k < 12; k++)
      run_field($urandom_range(1, 3), $urandom_range(0, 10), 1'($urandom_range(0, 1)), 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule